// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage Pipeline

This block decides when a five-stage in-order pipeline must abandon normal flow because of a trap seen at the execute stage. A trap can be an arithmetic fault raised by the instruction in execute, such as overflow, or an external interrupt request that is attached to that same instruction. When a trap is accepted, the block flushes the younger stages in the same cycle and redirects fetch to a fixed handler entry address. The memory and write-back stages are never flushed, so older instructions retire normally.

On the clock edge that ends the accepting cycle, the block records two values. The trap address register holds the program counter of the execute-stage instruction. The reason register holds a numeric cause code. A fault kills the execute-stage instruction, so it writes nothing, and the return address is the faulting instruction itself. An interrupt lets the execute-stage instruction complete and flushes only fetch and decode, so the return address is the captured address plus the instruction step.

Once a trap has been accepted, the block is busy. Further traps are ignored until a resume pulse arrives. That pulse redirects fetch to the return address and clears the busy state.

Top module: `precise_trap_ctl`

## Requirements
- R1: While reset is held, and after it is released with no stimulus, `trap_active`, `epc` and `cause` are zero, and no flush or redirect output is asserted.
- R2: When `ex_vld` and `ex_fault` are high and the block is not busy, `flush_fetch`, `flush_decode` and `flush_exec` are all high in that same cycle.
- R3: When `ex_vld` and `irq_req` are high, `ex_fault` is low and the block is not busy, `flush_fetch` and `flush_decode` are high and `flush_exec` stays low.
- R4: In every cycle in which a trap is accepted, `redir` is high and `redir_pc` equals the `HANDLER_ADDR` parameter (default 0x400).
- R5: On the cycle after acceptance, `trap_active` is 1 and `epc` holds the accepted `ex_pc`. `cause` holds the value of `ex_fcode` for a fault, or the value 1 for an interrupt. Fault codes must differ from 1.
- R6: When a fault and an interrupt arrive in the same cycle, the fault is taken: the flushes follow R2, and `cause` records `ex_fcode`.
- R7: While `trap_active` is 1, `ex_fault` and `irq_req` cause no flush and no redirect, and they leave `epc` and `cause` unchanged.
- R8: A `resume` pulse while `trap_active` is 1 drives `redir` high in that cycle. `redir_pc` is `epc + RETURN_STEP` (default 4) when `cause` is 1, and `epc` otherwise. `trap_active` is 0 on the next cycle.
- R9: A `resume` pulse while `trap_active` is 0 and no trap is being accepted has no effect: `redir` stays low and `epc`, `cause` and `trap_active` keep their values.
- R10: When `ex_vld` is low, `ex_fault` and `irq_req` are ignored: no flush, no redirect, and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_vld | input | 1 | Execute stage holds a real instruction |
| ex_pc | input | PC_W | Program counter of the execute-stage instruction |
| ex_fault | input | 1 | Execute-stage instruction raised a fault |
| ex_fcode | input | CAUSE_W | Cause code of that fault |
| irq_req | input | 1 | External interrupt request |
| resume | input | 1 | Handler finished; return to the interrupted flow |
| flush_fetch | output | 1 | Squash the fetch-stage instruction |
| flush_decode | output | 1 | Squash the decode-stage instruction |
| flush_exec | output | 1 | Squash the execute-stage instruction (fault only) |
| redir | output | 1 | Override the next fetch address |
| redir_pc | output | PC_W | Fetch address used when `redir` is high |
| epc | output | PC_W | Captured trap address |
| cause | output | CAUSE_W | Captured cause code |
| trap_active | output | 1 | A trap has been taken and not yet resumed |

## Verification
A wrong busy flag shows at the ports in one of two ways. A trap may be accepted twice, which flushes and redirects during the handler. Or a trap may be lost, with no flush in the very cycle the fault is presented. Either appears in the same cycle as the next stimulus. A wrong `epc` or `cause` capture appears one cycle after acceptance on those outputs, and again at resume through `redir_pc`. That return address also separates the interrupt and fault paths: a wrong kind selection produces an off-by-step address.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [1:0] {
      TK_NONE  = 2'd0,
      TK_FAULT = 2'd1,
      TK_IRQ   = 2'd2
   } take_e;

   localparam int unsigned CAUSE_IRQ_CODE = 1;
   localparam int unsigned CAUSE_OVF_CODE = 2;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter int unsigned CAUSE_W      = 4,
   parameter bit          USE_EXT_CODE = 1'b1
) (
   input  logic               ex_vld,
   input  logic               ex_fault,
   input  logic [CAUSE_W-1:0] ex_fcode,
   input  logic               irq_req,
   input  logic               busy,
   output take_e              kind,
   output logic [CAUSE_W-1:0] code
);
   logic [CAUSE_W-1:0] fault_code;

   generate
      if (USE_EXT_CODE) begin : g_ext_code
         assign fault_code = ex_fcode;
      end else begin : g_fixed_code
         assign fault_code = CAUSE_W'(CAUSE_OVF_CODE);
      end
   endgenerate

   // The execute-stage instruction is the oldest possible trap source; its
   // own fault outranks an interrupt that would merely attach to it.
   always_comb begin
      kind = TK_NONE;
      if (ex_vld && !busy) begin
         if (ex_fault)      kind = TK_FAULT;
         else if (irq_req)  kind = TK_IRQ;
      end
   end

   assign code = (kind == TK_IRQ) ? CAUSE_W'(CAUSE_IRQ_CODE) : fault_code;
endmodule

// File: rtl/trap_state.sv
module trap_state
   import trap_pkg::*;
#(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned CAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  take_e              kind,
   input  logic [PC_W-1:0]    ex_pc,
   input  logic [CAUSE_W-1:0] code,
   input  logic               resume,
   output logic [PC_W-1:0]    epc,
   output logic [CAUSE_W-1:0] cause,
   output logic               busy
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc   <= '0;
         cause <= '0;
         busy  <= 1'b0;
      end else if (kind != TK_NONE) begin
         epc   <= ex_pc;
         cause <= code;
         busy  <= 1'b1;
      end else if (resume && busy) begin
         busy  <= 1'b0;
      end
   end
endmodule

// File: rtl/trap_redirect.sv
module trap_redirect
   import trap_pkg::*;
#(
   parameter int unsigned     PC_W         = 32,
   parameter int unsigned     CAUSE_W      = 4,
   parameter logic [PC_W-1:0] HANDLER_ADDR = 'h400,
   parameter int unsigned     RETURN_STEP  = 4
) (
   input  take_e              kind,
   input  logic               resume,
   input  logic               busy,
   input  logic [PC_W-1:0]    epc,
   input  logic [CAUSE_W-1:0] cause,
   output logic               flush_fetch,
   output logic               flush_decode,
   output logic               flush_exec,
   output logic               redir,
   output logic [PC_W-1:0]    redir_pc
);
   localparam logic [PC_W-1:0]    STEP     = PC_W'(RETURN_STEP);
   localparam logic [CAUSE_W-1:0] IRQ_CODE = CAUSE_W'(CAUSE_IRQ_CODE);

   logic            taking;
   logic            back;
   logic [PC_W-1:0] ret_pc;

   assign taking       = (kind != TK_NONE);
   assign back         = resume && busy;
   assign flush_fetch  = taking;
   assign flush_decode = taking;
   assign flush_exec   = (kind == TK_FAULT);

   // An interrupted instruction completed, so the return skips past it;
   // a faulting one was killed and runs again.
   assign ret_pc   = (cause == IRQ_CODE) ? (epc + STEP) : epc;
   assign redir    = taking || back;
   assign redir_pc = taking ? HANDLER_ADDR : ret_pc;
endmodule

// File: rtl/precise_trap_ctl.sv
module precise_trap_ctl
   import trap_pkg::*;
#(
   parameter int unsigned     PC_W         = 32,
   parameter int unsigned     CAUSE_W      = 4,
   parameter logic [PC_W-1:0] HANDLER_ADDR = 'h400,
   parameter int unsigned     RETURN_STEP  = 4,
   parameter bit              USE_EXT_CODE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ex_vld,
   input  logic [PC_W-1:0]    ex_pc,
   input  logic               ex_fault,
   input  logic [CAUSE_W-1:0] ex_fcode,
   input  logic               irq_req,
   input  logic               resume,
   output logic               flush_fetch,
   output logic               flush_decode,
   output logic               flush_exec,
   output logic               redir,
   output logic [PC_W-1:0]    redir_pc,
   output logic [PC_W-1:0]    epc,
   output logic [CAUSE_W-1:0] cause,
   output logic               trap_active
);
   generate
      if (CAUSE_W < 2) begin : g_bad_cause_w
         $error("CAUSE_W must hold both the interrupt and overflow codes");
      end
      if (PC_W < 8) begin : g_bad_pc_w
         $error("PC_W is too narrow");
      end
      if (RETURN_STEP == 0) begin : g_bad_step
         $error("RETURN_STEP must be non-zero");
      end
      if ((HANDLER_ADDR % RETURN_STEP) != 0) begin : g_bad_handler
         $error("HANDLER_ADDR must be aligned to RETURN_STEP");
      end
   endgenerate

   take_e              kind;
   logic [CAUSE_W-1:0] code;

   trap_arbiter #(
      .CAUSE_W      (CAUSE_W),
      .USE_EXT_CODE (USE_EXT_CODE)
   ) u_arb (
      .ex_vld   (ex_vld),
      .ex_fault (ex_fault),
      .ex_fcode (ex_fcode),
      .irq_req  (irq_req),
      .busy     (trap_active),
      .kind     (kind),
      .code     (code)
   );

   trap_state #(
      .PC_W    (PC_W),
      .CAUSE_W (CAUSE_W)
   ) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .kind   (kind),
      .ex_pc  (ex_pc),
      .code   (code),
      .resume (resume),
      .epc    (epc),
      .cause  (cause),
      .busy   (trap_active)
   );

   trap_redirect #(
      .PC_W         (PC_W),
      .CAUSE_W      (CAUSE_W),
      .HANDLER_ADDR (HANDLER_ADDR),
      .RETURN_STEP  (RETURN_STEP)
   ) u_redir (
      .kind         (kind),
      .resume       (resume),
      .busy         (trap_active),
      .epc          (epc),
      .cause        (cause),
      .flush_fetch  (flush_fetch),
      .flush_decode (flush_decode),
      .flush_exec   (flush_exec),
      .redir        (redir),
      .redir_pc     (redir_pc)
   );
endmodule

// File: rtl/trap_checker.sv
module trap_checker #(
   parameter int unsigned     PC_W         = 32,
   parameter logic [PC_W-1:0] HANDLER_ADDR = 'h400
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ex_vld,
   input logic            ex_fault,
   input logic            irq_req,
   input logic [PC_W-1:0] ex_pc,
   input logic            resume,
   input logic            flush_fetch,
   input logic            flush_decode,
   input logic            flush_exec,
   input logic            redir,
   input logic [PC_W-1:0] redir_pc,
   input logic [PC_W-1:0] epc,
   input logic            trap_active
);
   p_flush_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flush_exec |-> (flush_fetch && flush_decode));

   p_irq_keeps_ex_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_fetch && !ex_fault) |-> !flush_exec);

   p_handler_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flush_fetch |-> (redir && redir_pc == HANDLER_ADDR));

   p_epc_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_fetch |=> (trap_active && epc == $past(ex_pc)));

   p_fault_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_vld && ex_fault && !trap_active) |-> flush_exec);

   p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_active |-> !flush_fetch);

   p_resume_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_active && resume) |=> !trap_active);

   p_idle_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_active && !flush_fetch) |-> !redir);

   p_no_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_vld |-> !flush_fetch);
endmodule

bind precise_trap_ctl trap_checker #(
   .PC_W         (PC_W),
   .HANDLER_ADDR (HANDLER_ADDR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ex_vld       (ex_vld),
   .ex_fault     (ex_fault),
   .irq_req      (irq_req),
   .ex_pc        (ex_pc),
   .resume       (resume),
   .flush_fetch  (flush_fetch),
   .flush_decode (flush_decode),
   .flush_exec   (flush_exec),
   .redir        (redir),
   .redir_pc     (redir_pc),
   .epc          (epc),
   .trap_active  (trap_active)
);

// File: tb/sim_precise_trap_ctl.sv
`timescale 1ns/1ps
module sim_precise_trap_ctl;
   localparam int unsigned PC_W    = 32;
   localparam int unsigned CAUSE_W = 4;
   localparam logic [31:0] HADDR   = 32'h400;
   localparam logic [31:0] STEP    = 32'd4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               ex_vld = 1'b0;
   logic [PC_W-1:0]    ex_pc = '0;
   logic               ex_fault = 1'b0;
   logic [CAUSE_W-1:0] ex_fcode = '0;
   logic               irq_req = 1'b0;
   logic               resume = 1'b0;
   logic               flush_fetch, flush_decode, flush_exec, redir, trap_active;
   logic [PC_W-1:0]    redir_pc, epc;
   logic [CAUSE_W-1:0] cause;

   always #10 clk = ~clk;

   precise_trap_ctl #(.PC_W(PC_W), .CAUSE_W(CAUSE_W), .HANDLER_ADDR(HADDR)) u0 (
      .clk(clk), .rst_n(rst_n), .ex_vld(ex_vld), .ex_pc(ex_pc),
      .ex_fault(ex_fault), .ex_fcode(ex_fcode), .irq_req(irq_req),
      .resume(resume), .flush_fetch(flush_fetch), .flush_decode(flush_decode),
      .flush_exec(flush_exec), .redir(redir), .redir_pc(redir_pc),
      .epc(epc), .cause(cause), .trap_active(trap_active));

   int n_cmp = 0;
   int n_bad = 0;

   // bench model of the architectural state
   bit          m_busy  = 1'b0;
   logic [31:0] m_epc   = '0;
   logic [3:0]  m_cause = '0;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic bit f_take_fault(bit v, bit f, bit busy);
      return v && f && !busy;
   endfunction

   function automatic bit f_take_irq(bit v, bit f, bit i, bit busy);
      return v && !f && i && !busy;
   endfunction

   function automatic logic [31:0] f_return(logic [31:0] e, logic [3:0] c);
      return (c == 4'd1) ? e + STEP : e;
   endfunction

   task automatic cycle(string tag, bit v, bit f, logic [3:0] code, bit i, bit r,
                        logic [31:0] pc);
      bit tf, ti, back;
      @(negedge clk);
      ex_vld = v; ex_fault = f; ex_fcode = code; irq_req = i; resume = r; ex_pc = pc;
      #2;
      tf   = f_take_fault(v, f, m_busy);
      ti   = f_take_irq(v, f, i, m_busy);
      back = r && m_busy;
      chk(tag, "trap_active", 32'(trap_active), 32'(m_busy));
      chk(tag, "epc", epc, m_epc);
      chk(tag, "cause", 32'(cause), 32'(m_cause));
      chk(tag, "flush_fetch", 32'(flush_fetch), 32'(tf || ti));
      chk(tag, "flush_decode", 32'(flush_decode), 32'(tf || ti));
      chk(tag, "flush_exec", 32'(flush_exec), 32'(tf));
      chk(tag, "redir", 32'(redir), 32'(tf || ti || back));
      if (tf || ti)  chk(tag, "redir_pc", redir_pc, HADDR);
      else if (back) chk(tag, "redir_pc", redir_pc, f_return(m_epc, m_cause));
      if (tf || ti) begin
         m_busy  = 1'b1;
         m_epc   = pc;
         m_cause = tf ? code : 4'd1;
      end else if (back) begin
         m_busy = 1'b0;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5eed);
      // R1: reset state, with stimulus held off
      repeat (3) @(negedge clk);
      #2;
      chk("R1", "trap_active", 32'(trap_active), 32'd0);
      chk("R1", "epc", epc, 32'd0);
      chk("R1", "cause", 32'(cause), 32'd0);
      chk("R1", "redir", 32'(redir), 32'd0);
      chk("R1", "flush_fetch", 32'(flush_fetch), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      cycle("R1", 0, 0, 4'd0, 0, 0, 32'h0);

      cycle("R10", 0, 1, 4'd2, 1, 0, 32'h80);   // R10: no instruction in execute
      cycle("R2 R4", 1, 1, 4'd2, 0, 0, 32'h100); // R2 R4: fault taken
      cycle("R7", 1, 1, 4'd5, 1, 0, 32'h200);   // R7: ignored while busy, R5 state
      cycle("R8", 0, 0, 4'd0, 0, 1, 32'h0);     // R8: fault return = epc
      cycle("R9", 0, 0, 4'd0, 0, 1, 32'h0);     // R9: resume when idle
      cycle("R3", 1, 0, 4'd0, 1, 0, 32'h300);   // R3: interrupt keeps execute
      cycle("R5", 0, 0, 4'd0, 0, 0, 32'h0);     // R5: cause 1, epc 0x300
      cycle("R8", 0, 0, 4'd0, 0, 1, 32'h0);     // R8: interrupt return = epc+4
      cycle("R6", 1, 1, 4'd3, 1, 0, 32'h500);   // R6: fault beats interrupt
      cycle("R5", 0, 0, 4'd0, 0, 0, 32'h0);
      cycle("R8", 1, 1, 4'd7, 1, 1, 32'h600);   // R8: resume wins, new trap dropped
      cycle("R2", 1, 1, 4'd9, 0, 0, 32'h700);

      for (int k = 0; k < 3000; k++) begin
         bit v, f, i, r;
         logic [3:0] code;
         v    = ($urandom % 10) < 8;
         f    = ($urandom % 100) < 15;
         i    = ($urandom % 100) < 15;
         r    = m_busy ? (($urandom % 100) < 20) : (($urandom % 100) < 5);
         code = 4'(2 + ($urandom % 14));
         cycle("rand", v, f, code, i, r, {$urandom} & 32'hFFFF_FFFC);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule